// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block executes the bitwise operations of a processor datapath: AND, OR, XOR, a one-operand complement, and a compare-style TEST. TEST computes the AND but leaves the destination alone. Operands are 32-bit buses, and a width select limits the operation to 8, 16 or 32 bits. The block also produces the status flags that a logic instruction leaves behind on a classic flag-based processor.

A request is one cycle of `valid_i`, carrying the opcode, the width, and the destination and source values. One clock later the registered result and flags appear, marked by a one-cycle `done_o` pulse. At the same time `wr_en_o` says whether the destination register should be written back. The carry and overflow flags are always cleared, because a bitwise operation cannot carry. The zero, sign and parity flags come from the result at the selected width. The auxiliary flag is not produced. The surrounding datapath keeps its old value and treats it as undefined.

Top module: `logic_unit`

## Requirements
- R1: The opcode selects the operation: 0 = AND, 1 = OR, 2 = XOR, 3 = NOT, 4 = TEST. The first three combine `dst_i` and `src_i` bit by bit. NOT complements `dst_i`, and `src_i` has no effect on its result or flags.
- R2: After every completed operation, `cf_o` and `of_o` are 0.
- R3: `zf_o` is 1 exactly when the result at the selected width is zero.
- R4: `sf_o` equals the most significant bit of the result at the selected width: bit 7, bit 15 or bit 31.
- R5: `pf_o` is 1 when bits 7..0 of the result hold an even number of ones.
- R6: The width select is encoded as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 32 bits. Result bits above the selected width are 0, and operand bits above the width do not affect the flags.
- R7: TEST (opcode 4) returns the AND result on `result_o` and updates the flags, but `wr_en_o` stays 0.
- R8: A request accepted on a clock edge with `valid_i` high shows up on `result_o` and the flags after that edge. `done_o` is high for that one cycle. `wr_en_o` is high in the same cycle for every opcode except TEST. Back-to-back requests give back-to-back results.
- R9: A cycle with `valid_i` low, or with an opcode of 5 to 7, raises neither `done_o` nor `wr_en_o`. It leaves `result_o` and all flags at their previous values.
- R10: While `rst_ni` is low, `result_o`, all flags, `done_o` and `wr_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Operand width select |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source operand |
| result_o | output | 32 | Registered result, zero above the selected width |
| wr_en_o | output | 1 | Destination write-back enable |
| done_o | output | 1 | Result and flags updated this cycle |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Parity flag |

## Verification
The hardest condition to reach from the ports is a flag that must ignore operand bits lying outside the selected width. The stimulus for this sets the upper operand bits to values that would flip zero, sign or parity at 32 bits, and then runs the operation at 8 and 16 bits. A second hard case is the hold behaviour of an illegal opcode. It matters only when the flags already carry non-reset values. An operation with a known result therefore runs first, then the illegal request, and the outputs are compared against the earlier result.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_WIDTH = 3;   // 8, 16, 32
  localparam int unsigned PAR_W   = 8;

  typedef enum logic [2:0] {
    LU_AND  = 3'd0,
    LU_OR   = 3'd1,
    LU_XOR  = 3'd2,
    LU_NOT  = 3'd3,
    LU_TEST = 3'd4
  } lu_op_e;

  typedef enum logic [1:0] {
    LU_W8   = 2'd0,
    LU_W16  = 2'd1,
    LU_W32  = 2'd2,
    LU_WRSV = 2'd3
  } lu_width_e;

  typedef struct packed {
    logic cf;
    logic of;
    logic zf;
    logic sf;
    logic pf;
  } lu_flags_t;

  function automatic logic lu_op_legal(input logic [2:0] op);
    return op <= 3'd4;
  endfunction
endpackage

// File: rtl/lu_op.sv
module lu_op
  import lu_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] raw_o
);
  always_comb begin
    unique case (op_i)
      LU_AND, LU_TEST: raw_o = dst_i & src_i;
      LU_OR:           raw_o = dst_i | src_i;
      LU_XOR:          raw_o = dst_i ^ src_i;
      LU_NOT:          raw_o = ~dst_i;
      default:         raw_o = '0;
    endcase
  end
endmodule

// File: rtl/lu_mask.sv
module lu_mask
  import lu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = N_WIDTH
) (
  input  logic [1:0]    width_i,
  input  logic [DW-1:0] raw_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] mask_w [NW];

  for (genvar g = 0; g < NW; g++) begin : g_mask
    localparam int unsigned BITS = 8 << g;
    assign mask_w[g] = {DW{1'b1}} >> (DW - BITS);
  end

  logic [DW-1:0] mask_sel;
  always_comb begin
    if (width_i >= 2'(NW)) mask_sel = mask_w[NW-1];
    else                   mask_sel = mask_w[width_i];
  end

  assign res_o = raw_i & mask_sel;
endmodule

// File: rtl/lu_flags.sv
module lu_flags
  import lu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = N_WIDTH
) (
  input  logic [1:0]    width_i,
  input  logic [DW-1:0] res_i,
  output lu_flags_t     flags_o
);
  logic [NW-1:0] msb_w;

  for (genvar g = 0; g < NW; g++) begin : g_msb
    localparam int unsigned TOP = (8 << g) - 1;
    assign msb_w[g] = res_i[TOP];
  end

  logic sign;
  always_comb begin
    if (width_i >= 2'(NW)) sign = msb_w[NW-1];
    else                   sign = msb_w[width_i];
  end

  // res_i is already masked to the selected width
  assign flags_o.cf = 1'b0;
  assign flags_o.of = 1'b0;
  assign flags_o.zf = (res_i == '0);
  assign flags_o.sf = sign;
  assign flags_o.pf = ~^res_i[PAR_W-1:0];
endmodule

// File: rtl/logic_unit.sv
module logic_unit
  import lu_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [2:0]  op_i,
  input  logic [1:0]  width_i,
  input  logic [31:0] dst_i,
  input  logic [31:0] src_i,
  output logic [31:0] result_o,
  output logic        wr_en_o,
  output logic        done_o,
  output logic        cf_o,
  output logic        of_o,
  output logic        zf_o,
  output logic        sf_o,
  output logic        pf_o
);
  logic [DATA_W-1:0] raw, res_d, res_q;
  lu_flags_t         flags_d, flags_q;
  logic              accept;

  lu_op #(.DW(DATA_W)) i_op (
    .op_i  (op_i),
    .dst_i (dst_i),
    .src_i (src_i),
    .raw_o (raw)
  );

  lu_mask #(.DW(DATA_W), .NW(N_WIDTH)) i_mask (
    .width_i (width_i),
    .raw_i   (raw),
    .res_o   (res_d)
  );

  lu_flags #(.DW(DATA_W), .NW(N_WIDTH)) i_flags (
    .width_i (width_i),
    .res_i   (res_d),
    .flags_o (flags_d)
  );

  assign accept = valid_i && lu_op_legal(op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      done_o  <= accept;
      wr_en_o <= accept && (op_i != LU_TEST);
      if (accept) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign result_o = res_q;
  assign cf_o     = flags_q.cf;
  assign of_o     = flags_q.of;
  assign zf_o     = flags_q.zf;
  assign sf_o     = flags_q.sf;
  assign pf_o     = flags_q.pf;
endmodule

// File: rtl/lu_checker.sv
module lu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [1:0]  width_i,
  input logic [31:0] dst_i,
  input logic [31:0] src_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic        done_o,
  input logic        cf_o,
  input logic        of_o,
  input logic        zf_o,
  input logic        sf_o,
  input logic        pf_o
);
  AST_CF_OF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cf_o && !of_o)); // R2

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zf_o == (result_o == 32'h0))); // R3

  AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (done_o && !wr_en_o)); // R7

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4) |=> done_o); // R8

  AST_WRITE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o); // R8

  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd4 && width_i == 2'd0) |=> (result_o[31:8] == 24'h0)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i <= 3'd4) |=>
      (!done_o && !wr_en_o && $stable(result_o) && $stable(zf_o) &&
       $stable(sf_o) && $stable(pf_o))); // R9
endmodule

bind logic_unit lu_checker i_lu_checker (.*);

// File: tb/test_logic_unit.sv
module test_logic_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  width_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, done_o, cf_o, of_o, zf_o, sf_o, pf_o;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic        wr, zf, sf, pf;
  } exp_t;

  exp_t queue_q[$];
  exp_t last;
  int   checks = 0;
  int   errors = 0;

  always #10 clk_i = ~clk_i;   // 50 MHz

  logic_unit i_logic_unit (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [1:0] w,
                                 input logic [31:0] d, input logic [31:0] s, input string tag);
    exp_t e;
    logic [31:0] r, m;
    case (op)
      3'd0, 3'd4: r = d & s;
      3'd1:       r = d | s;
      3'd2:       r = d ^ s;
      default:    r = ~d;
    endcase
    case (w)
      2'd0:    m = 32'h0000_00ff;
      2'd1:    m = 32'h0000_ffff;
      default: m = 32'hffff_ffff;
    endcase
    r = r & m;
    e.tag = tag;
    e.res = r;
    e.wr  = (op != 3'd4);
    e.zf  = (r == 0);
    e.sf  = (w == 2'd0) ? r[7] : (w == 2'd1) ? r[15] : r[31];
    e.pf  = ($countones(r[7:0]) % 2) == 0;
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] w,
                       input logic [31:0] d, input logic [31:0] s, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; width_i = w; dst_i = d; src_i = s;
    if (op <= 3'd4) queue_q.push_back(model(op, w, d, s, tag));
  endtask

  // idle one cycle, then verify outputs still show the last completed item
  task automatic idle_check(input string tag);
    @(negedge clk_i);
    valid_i = 1'b0; src_i = 32'hdead_beef;
    @(posedge clk_i); #5;
    check(!done_o && !wr_en_o, {tag, " strobes"}, {30'h0, done_o, wr_en_o}, 32'h0);
    check(result_o == last.res, {tag, " result"}, result_o, last.res);
    check({zf_o, sf_o, pf_o} == {last.zf, last.sf, last.pf}, {tag, " flags"},
          {29'h0, zf_o, sf_o, pf_o}, {29'h0, last.zf, last.sf, last.pf});
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (queue_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = queue_q.pop_front();
        check(result_o == e.res, {e.tag, " R1 R6 result"}, result_o, e.res);
        check(wr_en_o == e.wr, {e.tag, " R7 R8 write"}, 32'(wr_en_o), 32'(e.wr));
        check(!cf_o && !of_o, {e.tag, " R2 cf/of"}, {30'h0, cf_o, of_o}, 32'h0);
        check(zf_o == e.zf, {e.tag, " R3 zf"}, 32'(zf_o), 32'(e.zf));
        check(sf_o == e.sf, {e.tag, " R4 sf"}, 32'(sf_o), 32'(e.sf));
        check(pf_o == e.pf, {e.tag, " R5 pf"}, 32'(pf_o), 32'(e.pf));
        last = e;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    last = '{tag: "reset", res: 32'h0, wr: 1'b0, zf: 1'b0, sf: 1'b0, pf: 1'b0};
    repeat (3) @(posedge clk_i);
    #5;
    // R10 reset state
    check({result_o, wr_en_o, done_o, cf_o, of_o, zf_o, sf_o, pf_o} == '0,
          "R10 reset outputs", result_o | {25'h0, wr_en_o, done_o, cf_o, of_o, zf_o, sf_o, pf_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    drive(3'd0, 2'd2, 32'hf0f0_1234, 32'hff00_ff0f, "R1 and32");
    drive(3'd1, 2'd1, 32'h1234_0081, 32'h5678_7f00, "R1 or16");
    drive(3'd2, 2'd0, 32'hffff_ff5a, 32'h0000_00a5, "R1 xor8");
    drive(3'd3, 2'd0, 32'h0000_00f0, 32'hffff_ffff, "R1 not8");
    drive(3'd3, 2'd0, 32'h0000_00f0, 32'h0000_0000, "R1 not8 src ignored");
    drive(3'd4, 2'd2, 32'h8000_0003, 32'h8000_0001, "R7 test32");
    drive(3'd0, 2'd0, 32'hffff_ff00, 32'hffff_ffff, "R3 R6 zero8 high ignored");
    drive(3'd1, 2'd1, 32'h8000_0000, 32'h0000_0000, "R3 R6 zero16 high ignored");
    drive(3'd2, 2'd3, 32'h8000_0000, 32'h0000_0001, "R4 R6 width3 as 32");
    drive(3'd1, 2'd1, 32'h0000_8001, 32'h0000_0000, "R4 R5 sign16 odd");
    drive(3'd1, 2'd0, 32'h0000_0000, 32'h0000_0000, "R3 R5 zero parity");
    idle_check("R9 valid low hold");

    drive(3'd4, 2'd1, 32'h0000_00ff, 32'h0000_0f0f, "R7 test16");
    idle_check("R9 after test hold");
    drive(3'd0, 2'd2, 32'h8000_0007, 32'hffff_ffff, "R8 before illegal");
    drive(3'd5, 2'd2, 32'h0000_0000, 32'h0000_0000, "R9 op5");
    drive(3'd7, 2'd0, 32'h0000_0001, 32'h0000_0000, "R9 op7");
    idle_check("R9 illegal op hold");

    repeat (3) @(negedge clk_i);
    check(queue_q.size() == 0, "R8 all results delivered", queue_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule